// File: doc/BRIEF.md
# Segmented Page Table Walker

This block resolves a 16-bit virtual address into a 16-bit physical address when the translation cache misses. The virtual space is cut into eight equal 8 KB segments. An on-chip table holds, for each segment, the byte address in main memory where that segment's page table begins. A walk takes the segment number from the top three address bits and looks up that table. It reads the two-byte page table entry for the addressed 512-byte page from memory as two single-byte reads. It then returns the entry, the physical address and fault flags.

Requests arrive on a valid/ready handshake with a read/write flag. Only one walk is in flight at a time. The memory port issues one byte read per cycle of `memRdEn`, and the data comes back a fixed number of cycles later. Software-side logic fills the segment table through a simple write port. The walker does not write back dirty or aging bits, and it does not handle faults.

Top module: `pageWalker`

## Requirements
- R1: After reset, `reqReady` is 1, `rspValid` is 0 and `memRdEn` is 0. All eight segment bases are 0.
- R2: A request is accepted on a clock edge where `reqValid` and `reqReady` are both 1. `reqReady` is 0 from the cycle after acceptance through the response cycle, so address and flag changes after acceptance have no effect on the result.
- R3: A cycle with `cfgWrEn` high stores `cfgBase` as the base of segment `cfgIdx`. A walk uses the base that is held at its acceptance edge, so a table write during a walk affects only later walks.
- R4: Each walk issues exactly two reads. The first read is at E = base[VA[15:13]] + 2*VA[12:9]. The second read is at E+1, modulo 2^16, and is issued only after the first byte has returned.
- R5: Read data is taken exactly MEM_LAT cycles after the cycle in which `memRdEn` was high.
- R6: `rspPte` is {byte at E+1, byte at E}, with the first byte read forming bits [7:0].
- R7: The entry layout is frame number [15:9], valid [8], protection [7:5] with write-enable at [6], dirty [4] and aging [3:0]. On a walk without a fault, `rspPaddr` = {rspPte[15:9], VA[8:0]}.
- R8: If entry bit 8 is 0, `rspFaultInvalid` is 1, `rspFaultProt` is 0 and `rspPaddr` is 0.
- R9: If entry bit 8 is 1, the request is a write and entry bit 6 is 0, then `rspFaultProt` is 1 and `rspPaddr` is 0. A read never raises this fault.
- R10: `rspValid` is high for one cycle, 2*MEM_LAT+2 cycles after the acceptance edge. The fault flags are 0 whenever `rspValid` is 0, and `reqReady` is back at 1 in the cycle after the response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle and able to accept |
| reqVaddr | input | 16 | Virtual address to translate |
| reqWrite | input | 1 | 1 for a write access, 0 for a read |
| cfgWrEn | input | 1 | Segment table write strobe |
| cfgIdx | input | 3 | Segment number to write |
| cfgBase | input | 16 | Page table base address for that segment |
| memRdEn | output | 1 | Byte read request |
| memAddr | output | 16 | Byte address of the read |
| memRdData | input | 8 | Read data, MEM_LAT cycles after the request |
| rspValid | output | 1 | Result present (one cycle) |
| rspPte | output | 16 | Fetched page table entry |
| rspPaddr | output | 16 | Physical address, 0 on a fault |
| rspFaultInvalid | output | 1 | Entry not valid |
| rspFaultProt | output | 1 | Write to a write-protected page |

## Verification
The assertions check properties that hold on every cycle. Acceptance drops `reqReady`, and each response lasts one cycle and returns the walker to idle. Every walk issues exactly two reads, and the second address is one above the first. A fault never comes with a non-zero physical address, and the fault flags stay low outside a response. The bench scenarios are needed to show the values the properties cannot know. These are the entry address formed from the table base and page number, the little-endian assembly of the entry, and the exact sampling latency. They also include the wrap of the second read past 0xFFFF and the rule that a table write during a walk affects only the next walk. The bench sweeps every segment and page, for reads and writes, under several memory contents.

// File: rtl/walkPkg.sv
package walkPkg;

  typedef struct packed {
    logic loadReq;
    logic issueLo;
    logic issueHi;
    logic capLo;
    logic capHi;
    logic respond;
  } walkStrobes_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RDLO,
    ST_WTLO,
    ST_RDHI,
    ST_WTHI,
    ST_DONE
  } walkState_t;

endpackage

// File: rtl/walkCtrl.sv
module walkCtrl
  import walkPkg::*;
#(
  parameter int MEM_LAT = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  output logic         reqReady,
  output walkStrobes_t strobes
);

  localparam int LAT_W = (MEM_LAT > 1) ? $clog2(MEM_LAT) : 1;
  localparam logic [LAT_W-1:0] LAT_LAST = LAT_W'(MEM_LAT - 1);

  walkState_t stateQ, stateD;
  logic [LAT_W-1:0] latCnt;

  always_comb begin
    strobes = '0;
    reqReady = (stateQ == ST_IDLE);
    strobes.loadReq = reqValid && (stateQ == ST_IDLE);
    strobes.issueLo = (stateQ == ST_RDLO);
    strobes.issueHi = (stateQ == ST_RDHI);
    strobes.capLo   = (stateQ == ST_WTLO) && (latCnt == LAT_LAST);
    strobes.capHi   = (stateQ == ST_WTHI) && (latCnt == LAT_LAST);
    strobes.respond = (stateQ == ST_DONE);
  end

  always_comb begin
    stateD = stateQ;
    case (stateQ)
      ST_IDLE: if (reqValid) stateD = ST_RDLO;
      ST_RDLO: stateD = ST_WTLO;
      ST_WTLO: if (latCnt == LAT_LAST) stateD = ST_RDHI;
      ST_RDHI: stateD = ST_WTHI;
      ST_WTHI: if (latCnt == LAT_LAST) stateD = ST_DONE;
      ST_DONE: stateD = ST_IDLE;
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      latCnt <= '0;
    end else begin
      stateQ <= stateD;
      if (stateQ == ST_WTLO || stateQ == ST_WTHI) latCnt <= latCnt + 1'b1;
      else latCnt <= '0;
    end
  end

  // Read counter kept only for the checks below
  logic [2:0] readsSeen;
  always_ff @(posedge clk) begin
    if (!rstN) readsSeen <= '0;
    else if (strobes.loadReq) readsSeen <= '0;
    else if (strobes.issueLo || strobes.issueHi) readsSeen <= readsSeen + 3'd1;
  end

  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady); // R2

  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.respond |=> !strobes.respond && reqReady); // R10

  AST_TWO_READS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.respond |-> readsSeen == 3'd2); // R4

endmodule

// File: rtl/walkDatapath.sv
module walkDatapath
  import walkPkg::*;
#(
  parameter int VA_W      = 16,
  parameter int SEG_BITS  = 3,
  parameter int PAGE_BITS = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  walkStrobes_t        strobes,
  input  logic [VA_W-1:0]     reqVaddr,
  input  logic                reqWrite,
  input  logic                cfgWrEn,
  input  logic [SEG_BITS-1:0] cfgIdx,
  input  logic [VA_W-1:0]     cfgBase,
  output logic                memRdEn,
  output logic [VA_W-1:0]     memAddr,
  input  logic [7:0]          memRdData,
  output logic                rspValid,
  output logic [15:0]         rspPte,
  output logic [VA_W-1:0]     rspPaddr,
  output logic                rspFaultInvalid,
  output logic                rspFaultProt
);

  localparam int NUM_SEG = 1 << SEG_BITS;
  localparam int PG_W    = VA_W - SEG_BITS - PAGE_BITS;
  localparam int FRAME_W = VA_W - PAGE_BITS;
  localparam int VALID_BIT = 8;
  localparam int WEN_BIT   = 6;

  logic [VA_W-1:0]      segBase [NUM_SEG];
  logic [VA_W-1:0]      entryAddr;
  logic [PAGE_BITS-1:0] pageOff;
  logic                 isWrite;
  logic [15:0]          pteReg;

  logic [SEG_BITS-1:0] reqSeg;
  logic [PG_W-1:0]     reqPage;
  assign reqSeg  = reqVaddr[VA_W-1 -: SEG_BITS];
  assign reqPage = reqVaddr[PAGE_BITS +: PG_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SEG; i++) segBase[i] <= '0;
    end else if (cfgWrEn) begin
      segBase[cfgIdx] <= cfgBase;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entryAddr <= '0;
      pageOff   <= '0;
      isWrite   <= 1'b0;
      pteReg    <= '0;
    end else begin
      if (strobes.loadReq) begin
        entryAddr <= segBase[reqSeg] + {{(VA_W-PG_W-1){1'b0}}, reqPage, 1'b0};
        pageOff   <= reqVaddr[PAGE_BITS-1:0];
        isWrite   <= reqWrite;
      end
      if (strobes.capLo) pteReg[7:0]  <= memRdData;
      if (strobes.capHi) pteReg[15:8] <= memRdData;
    end
  end

  assign memRdEn = strobes.issueLo || strobes.issueHi;
  assign memAddr = strobes.issueHi ? entryAddr + 1'b1 : entryAddr;

  logic faultInv, faultProt;
  assign faultInv  = !pteReg[VALID_BIT];
  assign faultProt = pteReg[VALID_BIT] && isWrite && !pteReg[WEN_BIT];

  assign rspValid        = strobes.respond;
  assign rspPte          = pteReg;
  assign rspFaultInvalid = strobes.respond && faultInv;
  assign rspFaultProt    = strobes.respond && faultProt;
  assign rspPaddr = (strobes.respond && !faultInv && !faultProt)
                    ? {pteReg[15 -: FRAME_W], pageOff} : '0;

  // Address of the low-byte read, held for the check below
  logic [VA_W-1:0] loAddrSeen;
  always_ff @(posedge clk) begin
    if (!rstN) loAddrSeen <= '0;
    else if (strobes.issueLo) loAddrSeen <= memAddr;
  end

  AST_HI_FOLLOWS_LO: assert property (@(posedge clk) disable iff (!rstN)
    strobes.issueHi |-> memAddr == loAddrSeen + 1'b1); // R4

endmodule

// File: rtl/pageWalker.sv
module pageWalker
  import walkPkg::*;
#(
  parameter int VA_W      = 16,
  parameter int SEG_BITS  = 3,
  parameter int PAGE_BITS = 9,
  parameter int MEM_LAT   = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [VA_W-1:0]     reqVaddr,
  input  logic                reqWrite,
  input  logic                cfgWrEn,
  input  logic [SEG_BITS-1:0] cfgIdx,
  input  logic [VA_W-1:0]     cfgBase,
  output logic                memRdEn,
  output logic [VA_W-1:0]     memAddr,
  input  logic [7:0]          memRdData,
  output logic                rspValid,
  output logic [15:0]         rspPte,
  output logic [VA_W-1:0]     rspPaddr,
  output logic                rspFaultInvalid,
  output logic                rspFaultProt
);

  walkStrobes_t strobes;

  walkCtrl #(.MEM_LAT(MEM_LAT)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqReady (reqReady),
    .strobes  (strobes)
  );

  walkDatapath #(
    .VA_W      (VA_W),
    .SEG_BITS  (SEG_BITS),
    .PAGE_BITS (PAGE_BITS)
  ) i_dp (
    .clk             (clk),
    .rstN            (rstN),
    .strobes         (strobes),
    .reqVaddr        (reqVaddr),
    .reqWrite        (reqWrite),
    .cfgWrEn         (cfgWrEn),
    .cfgIdx          (cfgIdx),
    .cfgBase         (cfgBase),
    .memRdEn         (memRdEn),
    .memAddr         (memAddr),
    .memRdData       (memRdData),
    .rspValid        (rspValid),
    .rspPte          (rspPte),
    .rspPaddr        (rspPaddr),
    .rspFaultInvalid (rspFaultInvalid),
    .rspFaultProt    (rspFaultProt)
  );

  AST_FAULT_NO_PADDR: assert property (@(posedge clk) disable iff (!rstN)
    rspFaultInvalid || rspFaultProt |-> rspPaddr == '0); // R8 R9

  AST_FAULT_ONLY_IN_RSP: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> !rspFaultInvalid && !rspFaultProt); // R10

endmodule

// File: tb/test_pageWalker.sv
`timescale 1ns/1ps
module test_pageWalker;

  localparam int MEM_LAT = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [15:0] reqVaddr = '0;
  logic        reqWrite = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [2:0]  cfgIdx = '0;
  logic [15:0] cfgBase = '0;
  logic        memRdEn;
  logic [15:0] memAddr;
  logic [7:0]  memRdData;
  logic        rspValid;
  logic [15:0] rspPte;
  logic [15:0] rspPaddr;
  logic        rspFaultInvalid;
  logic        rspFaultProt;

  always #10 clk = ~clk;

  pageWalker #(.MEM_LAT(MEM_LAT)) i_pageWalker (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqVaddr(reqVaddr), .reqWrite(reqWrite),
    .cfgWrEn(cfgWrEn), .cfgIdx(cfgIdx), .cfgBase(cfgBase),
    .memRdEn(memRdEn), .memAddr(memAddr), .memRdData(memRdData),
    .rspValid(rspValid), .rspPte(rspPte), .rspPaddr(rspPaddr),
    .rspFaultInvalid(rspFaultInvalid), .rspFaultProt(rspFaultProt)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [7:0]  memKey = 8'h00;
  logic [15:0] expBase [8];
  int nOk = 0, nInv = 0, nProt = 0;

  function automatic logic [7:0] memByte(input logic [15:0] a);
    return (a[7:0] * 8'd29) ^ (a[15:8] * 8'd7) ^ memKey;
  endfunction

  // Memory model: fixed latency, filler data when no read was requested
  logic [7:0] pipe [MEM_LAT];
  always @(posedge clk) begin
    pipe[0] <= memRdEn ? memByte(memAddr) : 8'hC3;
    for (int i = 1; i < MEM_LAT; i++) pipe[i] <= pipe[i-1];
  end
  assign memRdData = pipe[MEM_LAT-1];

  // Read address monitor
  int rdCnt = 0;
  logic [15:0] rdA0, rdA1;
  always @(posedge clk) begin
    if (reqValid && reqReady) rdCnt <= 0;
    else if (memRdEn) begin
      if (rdCnt == 0) rdA0 <= memAddr;
      if (rdCnt == 1) rdA1 <= memAddr;
      rdCnt <= rdCnt + 1;
    end
  end

  task automatic check(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [2:0] idx, input logic [15:0] base);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgIdx = idx; cfgBase = base;
    @(negedge clk);
    cfgWrEn = 1'b0;
    expBase[idx] = base;
  endtask

  task automatic doWalk(input logic [15:0] va, input logic wr,
                        input bit midCfg, input logic [2:0] ci, input logic [15:0] cb);
    logic [15:0] ea, pte, expPa;
    logic expInv, expProt;
    int n;
    ea = expBase[va[15:13]] + {7'd0, va[12:9], 1'b0};
    pte = {memByte(ea + 16'd1), memByte(ea)};
    expInv  = !pte[8];
    expProt = pte[8] && wr && !pte[6];
    expPa   = (expInv || expProt) ? 16'h0 : {pte[15:9], va[8:0]};
    if (expInv) nInv++; else if (expProt) nProt++; else nOk++;

    @(negedge clk);
    check(reqReady === 1'b1, "R2 ready when idle", reqReady, 1);
    reqValid = 1'b1; reqVaddr = va; reqWrite = wr;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0; reqVaddr = ~va; reqWrite = ~wr;
    check(reqReady === 1'b0, "R2 ready low after accept", reqReady, 0);
    if (midCfg) begin cfgWrEn = 1'b1; cfgIdx = ci; cfgBase = cb; end
    n = 0;
    while (rspValid !== 1'b1 && n < 64) begin
      @(posedge clk); n++;
      @(negedge clk); cfgWrEn = 1'b0;
    end
    if (midCfg) expBase[ci] = cb;
    check(n == 2*MEM_LAT+2, "R10 response latency", n, 2*MEM_LAT+2);
    check(rdCnt == 2, "R4 read count", rdCnt, 2);
    check(rdA0 == ea, "R4 low byte address", rdA0, ea);
    check(rdA1 == ea + 16'd1, "R4 high byte address", rdA1, ea + 16'd1);
    check(rspPte == pte, "R5/R6 entry value", rspPte, pte);
    check(rspFaultInvalid == expInv, "R8 invalid fault", rspFaultInvalid, expInv);
    check(rspFaultProt == expProt, "R9 protection fault", rspFaultProt, expProt);
    check(rspPaddr == expPa, "R7 physical address", rspPaddr, expPa);
    check(reqReady === 1'b0, "R2 ready low in response", reqReady, 0);
    @(negedge clk);
    check(rspValid === 1'b0, "R10 single-cycle response", rspValid, 0);
    check(reqReady === 1'b1, "R10 ready after response", reqReady, 1);
    check(!rspFaultInvalid && !rspFaultProt, "R10 faults idle", {rspFaultInvalid, rspFaultProt}, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] keys [4];
    keys[0] = 8'h00; keys[1] = 8'h5A; keys[2] = 8'hA7; keys[3] = 8'hFF;
    for (int i = 0; i < 8; i++) expBase[i] = 16'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    check(reqReady === 1'b1, "R1 reset ready", reqReady, 1);
    check(rspValid === 1'b0, "R1 reset response", rspValid, 0);
    check(memRdEn === 1'b0, "R1 reset read enable", memRdEn, 0);

    // R1: walk with the reset table uses base 0
    doWalk(16'h3A05, 1'b0, 0, 3'd0, 16'h0);

    // R3: fill the table; segment 7 is placed so the high byte wraps past 0xFFFF
    for (int s = 0; s < 7; s++) cfgWrite(3'(s), 16'h0400 * 16'(s + 1) + 16'(s * 3));
    cfgWrite(3'd7, 16'hFFE1);

    for (int k = 0; k < 4; k++) begin
      memKey = keys[k];
      for (int s = 0; s < 8; s++)
        for (int p = 0; p < 16; p++)
          for (int w = 0; w < 2; w++)
            doWalk({3'(s), 4'(p), 9'((s * 37 + p * 11 + k * 5) & 9'h1FF)}, 1'(w), 0, 3'd0, 16'h0);
    end

    // R3: table write during a walk only affects the following walk
    memKey = 8'h3C;
    doWalk(16'h4600, 1'b0, 1, 3'd2, 16'h2222);
    doWalk(16'h4600, 1'b0, 0, 3'd0, 16'h0);
    check(rdA0 == 16'h2222 + 16'd6, "R3 new base used after write", rdA0, 16'h2228);

    check(nOk > 0, "R7 successful walks seen", nOk, 1);
    check(nInv > 0, "R8 invalid walks seen", nInv, 1);
    check(nProt > 0, "R9 protection walks seen", nProt, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule